// File: doc/BRIEF.md
# Serial Host Register Port with Burst Sequencing

This block is a chip-select-framed serial slave through which a host controller writes and reads a bank of eight 8-bit control registers and two 42-entry byte tables that hold waveform samples. A frame opens with the select line going low. The host then shifts in one command byte and one or more data bytes. Every byte travels least significant bit first. The command selects one register or table port, or it selects burst mode, which walks all 92 bytes in a fixed order. This order allows a complete initialisation or a complete dump in a single frame.

The port runs entirely in the system clock domain. Select, serial clock, serial input and polarity are synchronised and the serial clock edges are detected, so each SCLK high phase and each SCLK low phase must last at least 6 system clocks. The register contents drive the `cfg` output. The waveform engine reads both tables at once through a shared index. The serial output comes with an enable, and the pad turns the line to high impedance whenever the enable is low, so the serial input and output can share one wire.

Top module: `hrp_port`

## Requirements
- R1: After reset, all registers and table entries are zero and `sdo_oe` is low.
- R2: The command byte is the first byte of a frame. Bit 0 is the direction (1 = read, 0 = write), bits 4:1 are the address field, bit 7 set means burst, and bits 6:5 have no effect. SDI is taken on SCLK rising edges, LSB first.
- R3: Address field values 0 to 7 select a register. A single write stores the first data byte in that register, and `cfg[8*n+7:8*n]` changes only after the eighth bit of that byte. Later bytes in the same frame are ignored.
- R4: A single read returns the addressed value as the first data byte of the frame.
- R5: With `spol` high, SDO changes after SCLK rising edges and holds across the following falling edge, where the host samples it. Bit 0 of a byte is sampled on the falling edge that follows the last rising edge of the previous byte. With `spol` low, SDO changes after falling edges and is sampled on the next rising edge.
- R6: `sdo_oe` is high only while a read frame is in its data bytes. It stays low during the command byte, in write frames, after the last scheduled byte, and while select is high.
- R7: Address field 8 selects table A and 9 selects table B. Each table has an index that starts at 0 in every frame and steps after each full byte. Bytes after the 42nd in one frame are ignored.
- R8: Address field values 10 to 15 read as zero, and writes to them change nothing.
- R9: A burst with address field 0 moves registers 0 to 7, then table A entries 0 to 41, then table B entries 0 to 41: 92 bytes in all.
- R10: Select going high ends any frame. Bytes already complete stay written, while a partial byte and all later scheduled bytes leave their targets unchanged.
- R11: A burst command with a non-zero address field is rejected. The rest of the frame writes nothing and `sdo_oe` stays low.
- R12: `wav_a` and `wav_b` show entry `wav_idx` of tables A and B. They show zero when the index is 42 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| spol | input | 1 | Output edge polarity select |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial output enable for the pad |
| wav_idx | input | 6 | Table read index for the waveform engine |
| wav_a | output | 8 | Table A entry at `wav_idx` |
| wav_b | output | 8 | Table B entry at `wav_idx` |
| cfg | output | 64 | All eight registers, register n at bits 8n+7:8n |

## Verification
On every cycle the assertions check the following properties. SDO moves only on the serial edge selected by the polarity pin or on a byte load. The output enable drops once select is high, and it rises only straight after a command byte. The table indices never pass 42. The register outputs never change without a write strobe. The bench scenarios alone can show the rest: the burst order, the table stepping and its 42-byte limit, the discarding of partial and late bytes, the rejection of a non-zero burst address, and the read data values under both polarities. The bench shows these by comparing full-frame transfers against a byte-level model.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_DONE} hrp_state_e;
  typedef enum logic [1:0] {TG_REG, TG_TA, TG_TB, TG_NONE} hrp_tgt_e;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hrp_seq.sv
module hrp_seq
  import hrp_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DEPTH = 42,
  parameter int AW    = 4,
  parameter int IW    = 6,
  parameter int RW    = 3,
  parameter int TA_ADDR = 8,
  parameter int TB_ADDR = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic          spol_s,
  output logic          we_o,
  output hrp_tgt_e      tgt_o,
  output logic [RW-1:0] reg_sel_o,
  output logic [IW-1:0] tbl_idx_o,
  output logic [7:0]    wdata_o,
  input  logic [7:0]    rdata_i,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam logic [RW:0]   NREG_S  = (RW+1)'(NREG);
  localparam logic [AW-1:0] NREG_A  = AW'(NREG);
  localparam logic [AW-1:0] TA_A    = AW'(TA_ADDR);
  localparam logic [AW-1:0] TB_A    = AW'(TB_ADDR);
  localparam logic [IW-1:0] DEPTH_C = IW'(DEPTH);
  localparam logic [IW-1:0] LAST_C  = IW'(DEPTH - 1);

  hrp_state_e    st_q, st_n;
  logic          rd_q, rd_n, bst_q, bst_n, ld_q, ld_n;
  logic [AW-1:0] adr_q, adr_n;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    rx_q, rx_n, tx_q, tx_n;
  logic [RW:0]   rstep_q, rstep_n;
  logic [IW-1:0] ia_q, ia_n, ib_q, ib_n;
  logic          sdo_q, sdo_n, sclk_d;
  logic          rise_e, fall_e, byte_done, last_byte;
  logic [7:0]    rx_full;

  assign rise_e    = sclk_s & ~sclk_d;
  assign fall_e    = ~sclk_s & sclk_d;
  assign byte_done = rise_e && (bit_q == 3'd7);
  assign rx_full   = {sdi_s, rx_q[7:1]};
  assign wdata_o   = rx_full;

  // target of the current data byte
  always_comb begin
    tgt_o     = TG_NONE;
    reg_sel_o = adr_q[RW-1:0];
    if (bst_q) begin
      reg_sel_o = rstep_q[RW-1:0];
      if (rstep_q < NREG_S)    tgt_o = TG_REG;
      else if (ia_q < DEPTH_C) tgt_o = TG_TA;
      else if (ib_q < DEPTH_C) tgt_o = TG_TB;
    end else begin
      if (adr_q < NREG_A)      tgt_o = TG_REG;
      else if (adr_q == TA_A)  tgt_o = TG_TA;
      else if (adr_q == TB_A)  tgt_o = TG_TB;
    end
  end
  assign tbl_idx_o = (tgt_o == TG_TB) ? ib_q : ia_q;

  always_comb begin
    if (bst_q) last_byte = (tgt_o == TG_TB) && (ib_q == LAST_C);
    else case (tgt_o)
      TG_TA:   last_byte = (ia_q == LAST_C);
      TG_TB:   last_byte = (ib_q == LAST_C);
      default: last_byte = 1'b1;
    endcase
  end

  // frame and byte sequencing
  always_comb begin
    st_n = st_q; rd_n = rd_q; bst_n = bst_q; adr_n = adr_q;
    bit_n = bit_q; rx_n = rx_q; rstep_n = rstep_q;
    ia_n = ia_q; ib_n = ib_q; ld_n = 1'b0; we_o = 1'b0;
    if (cs_s) begin
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_n = ST_CMD; bit_n = '0; rstep_n = '0; ia_n = '0; ib_n = '0;
        end
        ST_CMD: if (rise_e) begin
          bit_n = bit_q + 3'd1;
          rx_n  = rx_full;
          if (byte_done) begin
            rd_n  = rx_full[0];
            adr_n = rx_full[AW:1];
            bst_n = rx_full[7];
            if (rx_full[7] && (rx_full[AW:1] != '0)) st_n = ST_DONE;
            else begin
              st_n = ST_DATA;
              ld_n = rx_full[0];
            end
          end
        end
        ST_DATA: if (rise_e) begin
          bit_n = bit_q + 3'd1;
          rx_n  = rx_full;
          if (byte_done) begin
            we_o = !rd_q && (tgt_o != TG_NONE);
            case (tgt_o)
              TG_REG:  if (bst_q) rstep_n = rstep_q + 1'b1;
              TG_TA:   ia_n = ia_q + 1'b1;
              TG_TB:   ib_n = ib_q + 1'b1;
              default: ;
            endcase
            if (last_byte) st_n = ST_DONE;
            else           ld_n = rd_q;
          end
        end
        default: ;
      endcase
    end
  end

  // serial output path
  always_comb begin
    tx_n  = tx_q;
    sdo_n = sdo_q;
    if (ld_q) begin
      if (spol_s) begin
        sdo_n = rdata_i[0];
        tx_n  = {1'b0, rdata_i[7:1]};
      end else begin
        tx_n  = rdata_i;
      end
    end else if ((st_q == ST_DATA) && rd_q) begin
      if ((spol_s && rise_e && !byte_done) || (!spol_s && fall_e)) begin
        sdo_n = tx_q[0];
        tx_n  = {1'b0, tx_q[7:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rd_q <= 1'b0; bst_q <= 1'b0; adr_q <= '0;
      bit_q <= '0; rx_q <= '0; rstep_q <= '0; ia_q <= '0; ib_q <= '0;
      ld_q <= 1'b0; tx_q <= '0; sdo_q <= 1'b0; sclk_d <= 1'b0;
    end else begin
      st_q <= st_n; rd_q <= rd_n; bst_q <= bst_n; adr_q <= adr_n;
      bit_q <= bit_n; rx_q <= rx_n; rstep_q <= rstep_n; ia_q <= ia_n;
      ib_q <= ib_n; ld_q <= ld_n; tx_q <= tx_n; sdo_q <= sdo_n;
      sclk_d <= sclk_s;
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = (st_q == ST_DATA) && rd_q;

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe_o);
  p_oe_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> $past(st_q) == ST_CMD);
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ia_q <= DEPTH_C) && (ib_q <= DEPTH_C));
  p_sdo_rise_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spol_s && !rise_e && !ld_q |=> $stable(sdo_o));
  p_sdo_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !spol_s && !fall_e |=> $stable(sdo_o));
endmodule

// File: rtl/hrp_store.sv
module hrp_store
  import hrp_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DEPTH = 42,
  parameter int IW    = 6,
  parameter int RW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  hrp_tgt_e         tgt_i,
  input  logic [RW-1:0]    reg_sel_i,
  input  logic [IW-1:0]    tbl_idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [IW-1:0]    wav_idx_i,
  output logic [7:0]       wav_a_o,
  output logic [7:0]       wav_b_o,
  output logic [NREG*8-1:0] cfg_o
);
  localparam logic [IW-1:0] DEPTH_C = IW'(DEPTH);

  logic [7:0] regs [NREG];
  logic [7:0] tbl_a [DEPTH];
  logic [7:0] tbl_b [DEPTH];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (we_i && (tgt_i == TG_REG) && (reg_sel_i == RW'(g))) regs[g] <= wdata_i;
    end
    assign cfg_o[g*8 +: 8] = regs[g];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_a[g] <= '0;
      else if (we_i && (tgt_i == TG_TA) && (tbl_idx_i == IW'(g))) tbl_a[g] <= wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_b[g] <= '0;
      else if (we_i && (tgt_i == TG_TB) && (tbl_idx_i == IW'(g))) tbl_b[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (tgt_i)
      TG_REG: rdata_o = regs[reg_sel_i];
      TG_TA:  if (tbl_idx_i < DEPTH_C) rdata_o = tbl_a[tbl_idx_i];
      TG_TB:  if (tbl_idx_i < DEPTH_C) rdata_o = tbl_b[tbl_idx_i];
      default: rdata_o = '0;
    endcase
  end

  assign wav_a_o = (wav_idx_i < DEPTH_C) ? tbl_a[wav_idx_i] : 8'h00;
  assign wav_b_o = (wav_idx_i < DEPTH_C) ? tbl_b[wav_idx_i] : 8'h00;

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/hrp_port.sv
module hrp_port
  import hrp_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DEPTH = 42,
  parameter int AW    = 4,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              spol,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [IW-1:0]     wav_idx,
  output logic [7:0]        wav_a,
  output logic [7:0]        wav_b,
  output logic [NREG*8-1:0] cfg
);
  localparam int RW = $clog2(NREG);

  logic [3:0]    pins_s;
  logic          we;
  hrp_tgt_e      tgt;
  logic [RW-1:0] reg_sel;
  logic [IW-1:0] tbl_idx;
  logic [7:0]    wdata, rdata;

  hrp_sync #(.W(4), .STAGES(2), .RST(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spol, sdi, sclk, cs_n}), .q(pins_s)
  );

  hrp_seq #(.NREG(NREG), .DEPTH(DEPTH), .AW(AW), .IW(IW), .RW(RW),
            .TA_ADDR(NREG), .TB_ADDR(NREG + 1)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s[0]), .sclk_s(pins_s[1]), .sdi_s(pins_s[2]), .spol_s(pins_s[3]),
    .we_o(we), .tgt_o(tgt), .reg_sel_o(reg_sel), .tbl_idx_o(tbl_idx),
    .wdata_o(wdata), .rdata_i(rdata), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  hrp_store #(.NREG(NREG), .DEPTH(DEPTH), .IW(IW), .RW(RW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_i(we), .tgt_i(tgt), .reg_sel_i(reg_sel), .tbl_idx_i(tbl_idx),
    .wdata_i(wdata), .rdata_o(rdata), .wav_idx_i(wav_idx),
    .wav_a_o(wav_a), .wav_b_o(wav_b), .cfg_o(cfg)
  );
endmodule

// File: tb/sim_hrp_port.sv
module sim_hrp_port;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, spol;
  logic sdo, sdo_oe;
  logic [5:0] wav_idx;
  logic [7:0] wav_a, wav_b;
  logic [63:0] cfg;

  int checks = 0, errors = 0;
  logic [7:0] m_reg [8];
  logic [7:0] m_a [42];
  logic [7:0] m_b [42];
  logic [7:0] tx_buf [100];
  logic [7:0] rx_buf [100];
  logic oe_and [100];
  logic oe_or [100];
  logic prev_fall, prev_oe;

  always #5 clk = ~clk;

  hrp_port u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
               .spol(spol), .sdo(sdo), .sdo_oe(sdo_oe), .wav_idx(wav_idx),
               .wav_a(wav_a), .wav_b(wav_b), .cfg(cfg));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  function automatic int kind_of(input bit bst, input logic [3:0] a, input int k, output int idx);
    idx = 0;
    if (bst) begin
      if (a != 0) return 4;
      if (k < 8)  begin idx = k;      return 0; end
      if (k < 50) begin idx = k - 8;  return 1; end
      if (k < 92) begin idx = k - 50; return 2; end
      return 4;
    end
    if (a < 8)  begin idx = int'(a); return (k == 0) ? 0 : 4; end
    if (a == 8) begin idx = k; return (k < 42) ? 1 : 4; end
    if (a == 9) begin idx = k; return (k < 42) ? 2 : 4; end
    return (k == 0) ? 3 : 4;
  endfunction

  function automatic logic [7:0] exp_byte(input int kd, input int idx);
    case (kd)
      0: return m_reg[idx];
      1: return m_a[idx];
      2: return m_b[idx];
      default: return 8'h00;
    endcase
  endfunction

  task automatic xfer(input logic [7:0] t, output logic [7:0] r, output logic a, output logic o);
    r = '0; a = 1'b1; o = 1'b0;
    if (spol) begin r[0] = prev_fall; a = prev_oe; o = prev_oe; end
    for (int i = 0; i < 8; i++) begin
      sdi = t[i]; sclk = 1'b0; half();
      if (!spol) begin r[i] = sdo; a &= sdo_oe; o |= sdo_oe; end
      sclk = 1'b1; half();
      if (spol) begin
        if (i < 7) begin r[i+1] = sdo; a &= sdo_oe; o |= sdo_oe; end
        else begin prev_fall = sdo; prev_oe = sdo_oe; end
      end
    end
  endtask

  task automatic do_frame(input logic [7:0] cmd, input int nb, input int extra);
    logic [7:0] r;
    logic a, o;
    sclk = 1'b0; cs_n = 1'b0; half(); half();
    prev_fall = 1'b0; prev_oe = 1'b0;
    xfer(cmd, r, a, o);
    for (int k = 0; k < nb; k++) xfer(tx_buf[k], rx_buf[k], oe_and[k], oe_or[k]);
    for (int e = 0; e < extra; e++) begin
      sdi = 1'($urandom); sclk = 1'b0; half(); sclk = 1'b1; half();
    end
    sclk = 1'b0; half(); cs_n = 1'b1; half(); half();
  endtask

  task automatic check_cfg(input string req);
    for (int i = 0; i < 8; i++) chk(cfg[i*8 +: 8] == m_reg[i], req, cfg[i*8 +: 8], m_reg[i]);
  endtask

  task automatic rd_frame(input bit bst, input logic [3:0] a, input int nb, input logic [1:0] junk, input string req);
    int kd, idx;
    logic [7:0] e;
    for (int k = 0; k < nb; k++) tx_buf[k] = 8'($urandom);
    do_frame({bst, junk, a, 1'b1}, nb, 0);
    for (int k = 0; k < nb; k++) begin
      kd = kind_of(bst, a, k, idx);
      if (kd < 4) begin
        e = exp_byte(kd, idx);
        chk(rx_buf[k] == e, req, rx_buf[k], e);
        chk(oe_and[k] == 1'b1, {req, " R6 oe during read"}, oe_and[k], 1);
      end else begin
        chk(oe_or[k] == 1'b0, {req, " R6 oe past schedule"}, oe_or[k], 0);
      end
    end
    chk(sdo_oe == 1'b0, "R6 idle oe", sdo_oe, 0);
  endtask

  task automatic wr_frame(input bit bst, input logic [3:0] a, input int nb, input logic [1:0] junk,
                          input int extra, input string req);
    int kd, idx;
    logic any_oe;
    do_frame({bst, junk, a, 1'b0}, nb, extra);
    any_oe = 1'b0;
    for (int k = 0; k < nb; k++) begin
      any_oe |= oe_or[k];
      kd = kind_of(bst, a, k, idx);
      case (kd)
        0: m_reg[idx] = tx_buf[k];
        1: m_a[idx] = tx_buf[k];
        2: m_b[idx] = tx_buf[k];
        default: ;
      endcase
    end
    chk(any_oe == 1'b0, "R6 oe in write frame", any_oe, 0);
    check_cfg(req);
  endtask

  task automatic wav_check(input int n);
    int ix;
    for (int i = 0; i < n; i++) begin
      ix = (i == 0) ? 42 : int'($urandom_range(0, 45));
      wav_idx = 6'(ix);
      @(negedge clk);
      chk(wav_a == ((ix < 42) ? m_a[ix] : 8'h00), "R12 table A view", wav_a, (ix < 42) ? m_a[ix] : 8'h00);
      chk(wav_b == ((ix < 42) ? m_b[ix] : 8'h00), "R12 table B view", wav_b, (ix < 42) ? m_b[ix] : 8'h00);
    end
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) tx_buf[k] = 8'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int op;
    logic [3:0] a;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; spol = 1'b0; wav_idx = '0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    for (int i = 0; i < 42; i++) begin m_a[i] = '0; m_b[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(cfg == 64'h0, "R1 registers", cfg, 0);
    chk(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
    wav_check(3);

    // R9 full burst write then read under both polarities (R5)
    spol = 1'b0; fill(92);
    wr_frame(1'b1, 4'd0, 92, 2'b11, 0, "R9 burst write");
    spol = 1'b1; rd_frame(1'b1, 4'd0, 92, 2'b00, "R9 R5 burst read rising-drive");
    wav_check(8);
    spol = 1'b0; rd_frame(1'b1, 4'd0, 93, 2'b10, "R5 burst read falling-drive");

    // R10 burst aborted mid byte
    spol = 1'b1; fill(31);
    wr_frame(1'b1, 4'd0, 30, 2'b01, 5, "R10 aborted burst");
    spol = 1'b0; rd_frame(1'b1, 4'd0, 92, 2'b00, "R10 readback");

    // R11 burst with non-zero address
    fill(6);
    wr_frame(1'b1, 4'd3, 6, 2'b00, 0, "R11 rejected burst write");
    rd_frame(1'b1, 4'd5, 3, 2'b00, "R11 rejected burst read");

    // R7 table ports with overrun
    fill(44);
    wr_frame(1'b0, 4'd8, 44, 2'b00, 0, "R7 table A stepping");
    rd_frame(1'b0, 4'd8, 44, 2'b11, "R7 table A read");
    spol = 1'b1; fill(5);
    wr_frame(1'b0, 4'd9, 5, 2'b10, 0, "R7 table B stepping");
    rd_frame(1'b0, 4'd9, 6, 2'b00, "R7 table B read");
    wav_check(8);

    // R8 unmapped addresses
    fill(2);
    wr_frame(1'b0, 4'd12, 2, 2'b00, 0, "R8 unmapped write");
    rd_frame(1'b0, 4'd13, 2, 2'b00, "R8 unmapped read");
    rd_frame(1'b1, 4'd0, 92, 2'b00, "R8 nothing disturbed");

    // R3 and R4 single register, extra bytes ignored
    spol = 1'b0; fill(3);
    wr_frame(1'b0, 4'd5, 3, 2'b11, 0, "R3 single write extra bytes");
    rd_frame(1'b0, 4'd5, 2, 2'b01, "R4 single read");
    fill(2);
    wr_frame(1'b0, 4'd2, 0, 2'b00, 6, "R10 partial single write");

    // random mix, R2 covers the ignored command bits
    for (int it = 0; it < 40; it++) begin
      op = int'($urandom_range(0, 4));
      spol = 1'($urandom);
      a = 4'($urandom);
      fill(8);
      case (op)
        0: wr_frame(1'b0, {1'b0, a[2:0]}, 1 + int'($urandom_range(0, 1)), 2'($urandom), 0, "R2 R3 random write");
        1: rd_frame(1'b0, {1'b0, a[2:0]}, 1, 2'($urandom), "R2 R4 random read");
        2: wr_frame(1'b0, {3'b100, a[0]}, 1 + int'($urandom_range(0, 5)), 2'($urandom), 0, "R7 random table write");
        3: rd_frame(1'b0, {3'b100, a[0]}, 1 + int'($urandom_range(0, 5)), 2'($urandom), "R7 random table read");
        default: rd_frame(1'b0, a, 1, 2'($urandom), "R2 random address read");
      endcase
    end

    spol = 1'b1; rd_frame(1'b1, 4'd0, 92, 2'b00, "R9 final burst read");
    wav_check(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule